// File: doc/BRIEF.md
# Pseudo-Static RAM Host Controller

This block lets synchronous on-chip logic use an external asynchronous pseudo-static RAM of 262144 words of 16 bits. A requester presents one word access at a time on a valid/ready handshake. The access carries an 18-bit word address, a write flag, 16 bits of write data and a 2-bit byte mask. The controller registers the request, then drives the active-low chip select, write strobe, read strobe and the two byte-lane strobes for a fixed number of clock cycles. That number covers the device access time. After the access it returns a single-cycle response pulse, with read data when the access was a read.

The wait length comes from two parameters: the device access time and the clock period. It is the access time divided by the period, rounded up, plus one cycle of margin. With a 70 ns device and a 10 ns clock this gives 8 cycles. The address pins stay frozen for the whole access. The controller drives the shared data pins only while it is writing. Every access is followed by a cycle in which chip select is high, so a read never starts while the write data is still on the pins. A request whose mask selects no byte is accepted and answered without touching the device.

Top module: `psram_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle and drops in the cycle after a request is accepted. The address, write flag, data and mask are taken at acceptance, so later changes on the request inputs do not affect the access in flight.
- R2: For a write, `mem_cs_n` and `mem_wr_n` are low and `mem_rd_n` is high throughout the access. `mem_dq` carries the accepted write data. `mem_lane_lo_n` is low when mask bit 0 is set and `mem_lane_hi_n` is low when mask bit 1 is set. Bit 0 selects data bits 7:0 and bit 1 selects bits 15:8, so only the selected bytes of the stored word change.
- R3: For a read, `mem_cs_n` and `mem_rd_n` are low and `mem_wr_n` is high, with the lane strobes set from the mask as in R2. In the response, `rsp_rdata` holds the device data in the selected byte lanes and zero in the lanes that were not selected.
- R4: Chip select stays low for exactly WAIT_CYC = ceil(T_ACCESS_NS / CLK_PERIOD_NS) + 1 consecutive cycles (8 by default). `rsp_valid` is high for exactly one cycle, the cycle after the last access cycle, which is WAIT_CYC + 1 cycles after the acceptance edge.
- R5: `mem_addr` does not change while `mem_cs_n` is low.
- R6: The controller drives `mem_dq` only while `mem_wr_n` is low. `mem_rd_n` is never low while `mem_wr_n` is low, and never low in the cycle right after `mem_wr_n` was low.
- R7: Whenever `mem_cs_n` is high, all other strobes are high. `mem_cs_n` is high for at least one cycle between any two accesses, including the response cycle.
- R8: A request with mask 00 is accepted. `rsp_valid` follows one cycle after acceptance with `rsp_rdata` zero, and no device strobe goes low.
- R9: While `rst_n` is low at a clock edge, the controller ends in the idle state: `req_ready` high, `rsp_valid` low, all strobes high and `mem_dq` released.
- R10: For a write, or for an empty request, `rsp_rdata` is zero in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Device address pins |
| mem_cs_n | output | 1 | Device chip select, active low |
| mem_wr_n | output | 1 | Device write strobe, active low |
| mem_rd_n | output | 1 | Device output enable, active low |
| mem_lane_hi_n | output | 1 | Upper byte lane strobe, active low |
| mem_lane_lo_n | output | 1 | Lower byte lane strobe, active low |
| mem_dq | inout | 16 | Shared data pins |

## Verification
The bench sweeps six addresses, including both ends of the address range and alternating bit patterns. Each address is tried with every write mask, and after each write it is read back with every read mask. A wrong lane decode, a swapped lane or a missing merge therefore shows up as a data mismatch against an arithmetic reference. The write data differs per address and per mask, so address aliasing and stale data are also told apart. The request inputs are scrambled right after acceptance, which separates registered request fields from fields taken straight from the inputs. The empty mask, the strobe length and the response latency are checked on every request. Continuous monitors watch the bus turnaround, the address hold and the idle strobes.

// File: rtl/psram_ctrl_pkg.sv
// Shared types and helpers for the pseudo-static RAM host controller.
// Assumes a 16-bit device word split into two byte lanes.
package psram_ctrl_pkg;

    localparam int WORD_W = 16;
    localparam int LANE_N = WORD_W / 8;

    // Sequencer phases: waiting for a request, device access, response/gap.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;

    // Number of whole clock cycles needed to cover a time, rounded up.
    function automatic int cycles_for(input int t_ns, input int period_ns);
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/psram_wait_cnt.sv
// Access wait timer: a down-counter loaded at the start of an access.
// Assumes LOAD_VAL >= 1; done is high when the counter has reached zero.
module psram_wait_cnt #(
    parameter int LOAD_VAL = 8,
    parameter int CNT_W    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    logic [CNT_W-1:0] cnt_q;

    // Load at access start, count down while the access runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(LOAD_VAL - 1);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Terminal count flag.
    always_comb begin
        done = (cnt_q == '0);
    end

    // R4: the counter never wraps from zero while the access runs.
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && done) |=> done);

endmodule

// File: rtl/psram_seq.sv
// Request sequencer: accepts one request at a time, registers its fields,
// steps through access and response/gap phases. Assumes the wait timer
// is loaded on the acceptance edge of a non-empty request.
module psram_seq
    import psram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [LANE_N-1:0] req_mask,
    output logic              req_ready,
    input  logic              cnt_done,
    output logic              cnt_load,
    output logic              cnt_run,
    output logic              acc_start,
    output logic              acc_active,
    output logic              acc_last,
    output logic              rsp_valid,
    output logic              cur_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_wdata,
    output logic [LANE_N-1:0] cur_mask
);

    seq_state_t state_q;
    logic       accept;
    logic       any_lane;

    // Handshake decode and phase flags.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        accept     = req_valid && req_ready;
        any_lane   = |req_mask;
        cnt_load   = accept && any_lane;
        acc_start  = accept;
        cnt_run    = (state_q == ST_ACC);
        acc_active = (state_q == ST_ACC);
        acc_last   = (state_q == ST_ACC) && cnt_done;
        rsp_valid  = (state_q == ST_GAP);
    end

    // Phase register: idle -> access -> gap -> idle; empty requests skip access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= any_lane ? ST_ACC : ST_GAP;
                ST_ACC:  if (cnt_done) state_q <= ST_GAP;
                ST_GAP:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture request fields on acceptance and hold them until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_mask  <= '0;
        end else if (accept) begin
            cur_write <= req_write;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            cur_mask  <= req_mask;
        end
    end

    // R1: no second acceptance while an access is in flight.
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4: the response is a single-cycle pulse.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: an empty request is answered in the next cycle.
    a_r8_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mask == '0) |=> rsp_valid);

endmodule

// File: rtl/psram_pad.sv
// Device-side pad logic: decodes the active-low strobes from the access
// phase, drives the data pins during writes only, and captures read data
// per byte lane on the last wait cycle. Assumes the sequencer holds the
// access fields stable while acc_active is high.
module psram_pad
    import psram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_active,
    input  logic              acc_start,
    input  logic              acc_last,
    input  logic              cur_write,
    input  logic [WORD_W-1:0] cur_wdata,
    input  logic [LANE_N-1:0] cur_mask,
    output logic              cs_n,
    output logic              wr_n,
    output logic              rd_n,
    output logic [LANE_N-1:0] lane_n,
    output logic [WORD_W-1:0] rdata,
    inout  wire  [WORD_W-1:0] dq
);

    logic drive_en;

    // Control strobe decode from the access phase.
    always_comb begin
        cs_n     = !acc_active;
        wr_n     = !(acc_active && cur_write);
        rd_n     = !(acc_active && !cur_write);
        drive_en = acc_active && cur_write;
    end

    // Data pins carry write data only during a write access.
    assign dq = drive_en ? cur_wdata : {WORD_W{1'bz}};

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        // Lane strobe for byte g.
        always_comb begin
            lane_n[g] = !(acc_active && cur_mask[g]);
        end

        // Lane capture: cleared at acceptance, loaded on the last read cycle.
        always_ff @(posedge clk) begin
            if (!rst_n || acc_start) begin
                rdata[g*8 +: 8] <= 8'h00;
            end else if (acc_last && !cur_write && cur_mask[g]) begin
                rdata[g*8 +: 8] <= dq[g*8 +: 8];
            end
        end
    end

    // R6: the read strobe never overlaps the write strobe.
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> wr_n);

    // R6: a write is followed by at least one cycle with the read strobe high.
    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_n) |-> rd_n);

    // R7: with chip select high, every other strobe is high too.
    a_r7_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (wr_n && rd_n && (&lane_n)));

endmodule

// File: rtl/psram_ctrl.sv
// Host controller for an asynchronous 16-bit pseudo-static RAM.
// Single-word accesses on a valid/ready handshake; the access wait is
// derived from the device access time and the clock period.
// Assumes one outstanding request and a device without refresh collisions.
module psram_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ACCESS_NS   = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              mem_lane_hi_n,
    output logic              mem_lane_lo_n,
    inout  wire  [15:0]       mem_dq
);

    localparam int WAIT_CYC = cycles_for(T_ACCESS_NS, CLK_PERIOD_NS) + 1;
    localparam int CNT_W    = $clog2(WAIT_CYC + 1);

    logic              cnt_done;
    logic              cnt_load;
    logic              cnt_run;
    logic              acc_start;
    logic              acc_active;
    logic              acc_last;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] cur_wdata;
    logic [LANE_N-1:0] cur_mask;
    logic [LANE_N-1:0] lane_n;

    psram_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .req_ready  (req_ready),
        .cnt_done   (cnt_done),
        .cnt_load   (cnt_load),
        .cnt_run    (cnt_run),
        .acc_start  (acc_start),
        .acc_active (acc_active),
        .acc_last   (acc_last),
        .rsp_valid  (rsp_valid),
        .cur_write  (cur_write),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .cur_mask   (cur_mask)
    );

    psram_wait_cnt #(.LOAD_VAL(WAIT_CYC), .CNT_W(CNT_W)) wait_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .run   (cnt_run),
        .done  (cnt_done)
    );

    psram_pad pad_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_active (acc_active),
        .acc_start  (acc_start),
        .acc_last   (acc_last),
        .cur_write  (cur_write),
        .cur_wdata  (cur_wdata),
        .cur_mask   (cur_mask),
        .cs_n       (mem_cs_n),
        .wr_n       (mem_wr_n),
        .rd_n       (mem_rd_n),
        .lane_n     (lane_n),
        .rdata      (rsp_rdata),
        .dq         (mem_dq)
    );

    // Pin mapping: held address and lane strobes.
    always_comb begin
        mem_addr      = cur_addr;
        mem_lane_lo_n = lane_n[0];
        mem_lane_hi_n = lane_n[1];
    end

    // Checker state: length of the current run of chip-select-low cycles.
    logic [CNT_W:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || mem_cs_n) begin
            low_run_q <= '0;
        end else begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    // R4: every access keeps chip select low for exactly WAIT_CYC cycles.
    a_r4_access_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n && !$past(mem_cs_n)) |-> (low_run_q == (CNT_W+1)'(WAIT_CYC)));

    // R5: the address is frozen while the device is selected.
    a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/psram_ctrl_tb_top.sv
// Self-checking bench: behavioural device model, arithmetic reference
// memory, sweep of addresses x write masks x read masks.
module psram_ctrl_tb_top;

    localparam int PERIOD   = 10;
    localparam int T_ACC    = 70;
    localparam int EXP_WAIT = (T_ACC + PERIOD - 1) / PERIOD + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_wr_n, mem_rd_n, mem_lane_hi_n, mem_lane_lo_n;
    wire  [15:0] dq;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    psram_ctrl #(.ADDR_W(18), .CLK_PERIOD_NS(PERIOD), .T_ACCESS_NS(T_ACC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n),
        .mem_rd_n(mem_rd_n), .mem_lane_hi_n(mem_lane_hi_n),
        .mem_lane_lo_n(mem_lane_lo_n), .mem_dq(dq)
    );

    // Device model storage and read output.
    logic [15:0] dev_mem [logic [17:0]];
    logic [15:0] ref_mem [logic [17:0]];
    logic [15:0] dev_q = 16'h0;
    logic [15:0] dev_w;
    logic        dev_rd;

    assign dev_rd  = !mem_cs_n && !mem_rd_n && mem_wr_n;
    assign dq[7:0]  = (dev_rd && !mem_lane_lo_n) ? dev_q[7:0]  : 8'bz;
    assign dq[15:8] = (dev_rd && !mem_lane_hi_n) ? dev_q[15:8] : 8'bz;

    always @(negedge clk) begin
        if (!mem_cs_n && !mem_wr_n) begin
            dev_w = dev_mem.exists(mem_addr) ? dev_mem[mem_addr] : 16'h0;
            if (!mem_lane_lo_n) dev_w[7:0]  = dq[7:0];
            if (!mem_lane_hi_n) dev_w[15:8] = dq[15:8];
            dev_mem[mem_addr] = dev_w;
        end
        dev_q = dev_mem.exists(mem_addr) ? dev_mem[mem_addr] : 16'h0;
    end

    // Continuous pin monitors (violation counters, reported at the end).
    int          viol_r5 = 0, viol_r6 = 0, viol_r7 = 0;
    logic        prev_wr_low = 1'b0, prev_cs_low = 1'b0;
    logic [17:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_cs_n && !(mem_wr_n && mem_rd_n && mem_lane_hi_n && mem_lane_lo_n))
                viol_r7++;
            if (!mem_rd_n && (prev_wr_low || !mem_wr_n)) viol_r6++;
            if (!mem_cs_n && prev_cs_low && mem_addr != prev_addr) viol_r5++;
        end
        prev_wr_low = !mem_wr_n;
        prev_cs_low = !mem_cs_n;
        prev_addr   = mem_addr;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_bits(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    // One request with full per-cycle checking.
    task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] wd,
                          input logic [1:0] m, input logic [15:0] exp_rd);
        int n, low;
        bit strobe_ok, ready_ok;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready when idle", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_mask = m;
        @(negedge clk);
        // Scramble the request inputs: the access must use the registered values.
        req_valid = 1'b0; req_write = !wr; req_addr = ~a; req_wdata = ~wd; req_mask = ~m;
        n = 1; low = 0; strobe_ok = 1'b1; ready_ok = 1'b1;
        while (!rsp_valid && n < 40) begin
            if (req_ready) ready_ok = 1'b0;
            if (!mem_cs_n) begin
                low++;
                if (mem_wr_n != !wr || mem_rd_n != wr || mem_lane_lo_n != !m[0] ||
                    mem_lane_hi_n != !m[1] || mem_addr != a || (wr && dq != wd))
                    strobe_ok = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        chk(ready_ok, "R1", "ready low during access", {31'd0, ready_ok}, 1);
        chk(strobe_ok, wr ? "R2" : "R3", "strobes/address/data during access",
            {31'd0, strobe_ok}, 1);
        if (m == 2'b00) begin
            chk(n == 1, "R8", "empty request latency", n, 1);
            chk(low == 0, "R8", "empty request strobes", low, 0);
        end else begin
            chk(n == EXP_WAIT + 1, "R4", "response latency", n, EXP_WAIT + 1);
            chk(low == EXP_WAIT, "R4", "chip select low cycles", low, EXP_WAIT);
        end
        chk(rsp_valid == 1'b1, "R4", "response seen", rsp_valid, 1);
        chk(mem_cs_n == 1'b1, "R7", "deselected in response cycle", mem_cs_n, 1);
        if (wr || m == 2'b00)
            chk(rsp_rdata == 16'h0, "R10", "no read data", rsp_rdata, 0);
        else
            chk(rsp_rdata == exp_rd, "R3", "read data by lane", rsp_rdata, exp_rd);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R4", "response one cycle", rsp_valid, 0);
    endtask

    // Apply a write to the reference memory.
    function automatic void ref_write(input logic [17:0] a, input logic [15:0] wd,
                                      input logic [1:0] m);
        logic [15:0] old, bm;
        old = ref_mem.exists(a) ? ref_mem[a] : 16'h0;
        bm  = lane_bits(m);
        ref_mem[a] = (old & ~bm) | (wd & bm);
    endfunction

    logic [17:0] addrs [6];

    initial begin
        addrs[0] = 18'h00000; addrs[1] = 18'h00001; addrs[2] = 18'h00155;
        addrs[3] = 18'h0AAAA; addrs[4] = 18'h2AAAA; addrs[5] = 18'h3FFFF;
        repeat (3) @(negedge clk);
        // R9: state while reset is held.
        chk(req_ready == 1'b1, "R9", "ready in reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R9", "no response in reset", rsp_valid, 0);
        chk({mem_cs_n, mem_wr_n, mem_rd_n, mem_lane_hi_n, mem_lane_lo_n} == 5'b11111,
            "R9", "strobes in reset",
            {mem_cs_n, mem_wr_n, mem_rd_n, mem_lane_hi_n, mem_lane_lo_n}, 5'b11111);
        rst_n = 1'b1;
        // Fill every address with a full-word pattern.
        for (int i = 0; i < 6; i++) begin
            logic [15:0] wd;
            wd = 16'(addrs[i] * 18'd40503) ^ 16'h5A3C;
            do_req(1'b1, addrs[i], wd, 2'b11, 16'h0);
            ref_write(addrs[i], wd, 2'b11);
        end
        // Sweep: every write mask at every address, then every read mask.
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 6; i++) begin
                logic [15:0] wd;
                wd = 16'(addrs[i] * 18'd7919 + 18'(m) * 18'h1111) ^ 16'hC3A5;
                do_req(1'b1, addrs[i], wd, 2'(m), 16'h0);
                ref_write(addrs[i], wd, 2'(m));
                for (int r = 0; r < 4; r++) begin
                    do_req(1'b0, addrs[i], 16'h0, 2'(r),
                           ref_mem[addrs[i]] & lane_bits(2'(r)));
                end
            end
        end
        chk(viol_r5 == 0, "R5", "address changed while selected", viol_r5, 0);
        chk(viol_r6 == 0, "R6", "read strobe overlap or no turnaround", viol_r6, 0);
        chk(viol_r7 == 0, "R7", "strobe low while deselected", viol_r7, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule